// File: doc/BRIEF.md
# Two-Cycle 8x8 Multiplier with Signed and Fractional Modes

This block multiplies two 8-bit operands and returns a 16-bit product, split into a high byte and a low byte. A two-bit signedness code selects how the operands are read: both unsigned, both two's complement, or the first operand signed and the second unsigned. A separate fractional bit shifts the product left by one place. In signed mode this gives a 1.15 fixed-point result from two 1.7 operands.

The caller pulses `start` for one cycle with the operands, the signedness code and the fractional bit present. Two cycles later `done` pulses, and the product and the two flags are valid. They hold until the next multiply completes. A new `start` may be issued on every cycle, and each one completes two cycles after it was issued. Writing the product into a register pair and decoding instructions are left to the surrounding logic. Only the zero flag and the carry flag are produced.

Top module: `mul8_fmul_core`

## Requirements
- R1: With sgn_sel = 0, both operands are unsigned and {prod_hi, prod_lo} equals the low 16 bits of opa*opb.
- R2: With sgn_sel = 1, both operands are two's complement and the result is the 16-bit two's-complement product.
- R3: With sgn_sel = 2, opa is two's complement and opb is unsigned. Only opa is sign-extended.
- R4: sgn_sel = 3 is treated exactly as sgn_sel = 0 (unsigned by unsigned).
- R5: With frac = 1, the result is the 16-bit product shifted left by one bit, with prod_lo bit 0 equal to 0 and the product's bit 15 discarded.
- R6: flag_c equals bit 15 of the product before any fractional shift.
- R7: flag_z is 1 exactly when the final 16-bit result (after any shift) is zero.
- R8: When start is high in cycle n, done is high for one cycle in cycle n+2 and low in cycle n+1.
- R9: The product and flags change only in a cycle where done is high. Without a start, done stays low and the outputs hold.
- R10: Starts on consecutive cycles are each accepted. Each returns its own result two cycles later.
- R11: After reset the outputs are zero: done = 0, prod_hi = prod_lo = 0, flag_z = 0, flag_c = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launches a multiply with the present operands and mode |
| sgn_sel | input | 2 | Signedness: 0 uu, 1 ss, 2 su, 3 uu |
| frac | input | 1 | Fractional mode: shift product left by one |
| opa | input | 8 | First operand (signed in codes 1 and 2) |
| opb | input | 8 | Second operand (signed in code 1 only) |
| prod_hi | output | 8 | Upper byte of the result |
| prod_lo | output | 8 | Lower byte of the result |
| done | output | 1 | One-cycle pulse when the result is valid |
| flag_z | output | 1 | Result-is-zero flag |
| flag_c | output | 1 | Bit 15 of the unshifted product |

## Verification
The assertions check four things on every cycle. Each done must follow a start by exactly two cycles. The result and flags must hold between done pulses. A fractional result must have its lowest bit clear. The zero flag must agree with the result. Only the bench scenarios can show that the arithmetic is correct in each signedness mode, that the carry comes from the unshifted product, and how the corner operands behave. These corners include -128 by -128, 0xFF by 0xFF in every mode, and back-to-back starts.

// File: rtl/mul8_pkg.sv
// Package: shared encodings and widths for the two-cycle multiplier.
// Assumes the signedness code is two bits wide; code 3 aliases unsigned.
package mul8_pkg;
    localparam int unsigned OP_W = 8;
    localparam int unsigned PR_W = 2 * OP_W;

    typedef enum logic [1:0] {
        SGN_UU  = 2'd0,
        SGN_SS  = 2'd1,
        SGN_SU  = 2'd2,
        SGN_UU2 = 2'd3
    } sgn_mode_e;

    // Stage-one payload carried between the input and product registers
    typedef struct packed {
        logic [PR_W-1:0] a_ext;
        logic [OP_W-1:0] b_raw;
        logic            b_signed;
        logic            frac;
    } mul_stage_t;
endpackage

// File: rtl/mul8_opnd_ext.sv
// Operand extender: decodes the signedness code and widens the first
// operand to twice its width, sign-extending it only when the code
// marks it signed. The second operand stays raw; a flag says whether
// its top bit carries negative weight. Purely combinational.
module mul8_opnd_ext #(
    parameter int unsigned W = 8
) (
    input  logic [1:0]     sgn_sel,
    input  logic [W-1:0]   a_in,
    input  logic [W-1:0]   b_in,
    output logic [2*W-1:0] a_ext,
    output logic [W-1:0]   b_out,
    output logic           b_signed
);
    import mul8_pkg::*;

    logic a_signed;

    // Decode which operands are treated as two's complement
    always_comb begin
        unique case (sgn_mode_e'(sgn_sel))
            SGN_SS:  begin a_signed = 1'b1; b_signed = 1'b1; end
            SGN_SU:  begin a_signed = 1'b1; b_signed = 1'b0; end
            default: begin a_signed = 1'b0; b_signed = 1'b0; end
        endcase
    end

    // Widen operand A, replicating its sign only when signed
    always_comb begin
        a_ext = {{W{a_signed & a_in[W-1]}}, a_in};
        b_out = b_in;
    end
endmodule

// File: rtl/mul8_pp_array.sv
// Partial-product array: forms one shifted copy of the widened first
// operand per bit of the second operand and sums them modulo 2^(2W).
// When the second operand is signed its top row is subtracted, giving
// the two's-complement product. Purely combinational.
module mul8_pp_array #(
    parameter int unsigned W = 8
) (
    input  logic [2*W-1:0] a_ext,
    input  logic [W-1:0]   b,
    input  logic           b_signed,
    output logic [2*W-1:0] product
);
    localparam int unsigned PW = 2 * W;

    logic [PW-1:0] pp [W];

    // One gated, shifted row per multiplier bit
    for (genvar gi = 0; gi < W; gi++) begin : g_row
        assign pp[gi] = b[gi] ? (a_ext << gi) : '0;
    end

    // Accumulate rows; the sign row is subtracted in signed mode
    always_comb begin
        product = '0;
        for (int i = 0; i < W; i++) begin
            if ((i == W - 1) && b_signed) begin
                product = product - pp[i];
            end else begin
                product = product + pp[i];
            end
        end
    end
endmodule

// File: rtl/mul8_post.sv
// Post-processing: applies the optional fractional left shift and
// derives the zero and carry flags. Carry is taken from the top bit of
// the product before the shift; zero is judged on the final value.
module mul8_post #(
    parameter int unsigned W = 8
) (
    input  logic [2*W-1:0] product,
    input  logic           frac,
    output logic [2*W-1:0] result,
    output logic           z,
    output logic           c
);
    // Shift for fractional mode and form both flags
    always_comb begin
        result = frac ? {product[2*W-2:0], 1'b0} : product;
        c      = product[2*W-1];
        z      = (result == '0);
    end
endmodule

// File: rtl/mul8_fmul_core.sv
// Two-cycle 8x8 multiplier top. Cycle one registers the extended
// operands; cycle two registers the product, flags and the done pulse.
// A start may arrive every cycle. Outputs only change when done is high.
// Assumes synchronous active-low reset.
module mul8_fmul_core #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   sgn_sel,
    input  logic         frac,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] prod_hi,
    output logic [W-1:0] prod_lo,
    output logic         done,
    output logic         flag_z,
    output logic         flag_c
);
    localparam int unsigned PW = 2 * W;

    logic [PW-1:0] a_ext_d;
    logic [W-1:0]  b_d;
    logic          bsig_d;

    logic [PW-1:0] s1_a;
    logic [W-1:0]  s1_b;
    logic          s1_bsig;
    logic          s1_frac;
    logic          s1_vld;

    logic [PW-1:0] prod_w;
    logic [PW-1:0] res_w;
    logic          z_w;
    logic          c_w;

    logic [PW-1:0] res_q;
    logic          frac_q;

    mul8_opnd_ext #(.W(W)) ext_i (
        .sgn_sel (sgn_sel),
        .a_in    (opa),
        .b_in    (opb),
        .a_ext   (a_ext_d),
        .b_out   (b_d),
        .b_signed(bsig_d)
    );

    // Stage one: capture widened operands and mode on start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_a    <= '0;
            s1_b    <= '0;
            s1_bsig <= 1'b0;
            s1_frac <= 1'b0;
            s1_vld  <= 1'b0;
        end else begin
            s1_vld <= start;
            if (start) begin
                s1_a    <= a_ext_d;
                s1_b    <= b_d;
                s1_bsig <= bsig_d;
                s1_frac <= frac;
            end
        end
    end

    mul8_pp_array #(.W(W)) arr_i (
        .a_ext   (s1_a),
        .b       (s1_b),
        .b_signed(s1_bsig),
        .product (prod_w)
    );

    mul8_post #(.W(W)) post_i (
        .product(prod_w),
        .frac   (s1_frac),
        .result (res_w),
        .z      (z_w),
        .c      (c_w)
    );

    // Stage two: register result and flags, pulse done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            flag_z <= 1'b0;
            flag_c <= 1'b0;
            frac_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= s1_vld;
            if (s1_vld) begin
                res_q  <= res_w;
                flag_z <= z_w;
                flag_c <= c_w;
                frac_q <= s1_frac;
            end
        end
    end

    assign prod_hi = res_q[PW-1:W];
    assign prod_lo = res_q[W-1:0];

    // R8: every start is answered by done two cycles later
    a_r8_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> ##1 done);

    // R8: done never appears without a start two cycles earlier
    a_r8_done_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(start, 2));

    // R9: outputs hold in cycles without done
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(prod_hi) && $stable(prod_lo) && $stable(flag_z) && $stable(flag_c)));

    // R5: a fractional result always has a clear least significant bit
    a_r5_frac_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        (done && frac_q) |-> (prod_lo[0] == 1'b0));

    // R7: zero flag agrees with the presented result
    a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_z == ({prod_hi, prod_lo} == '0)));
endmodule

// File: tb/mul8_fmul_core_tb.sv
module mul8_fmul_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] sgn_sel = 2'd0;
    logic       frac = 1'b0;
    logic [7:0] opa = 8'd0;
    logic [7:0] opb = 8'd0;
    logic [7:0] prod_hi, prod_lo;
    logic       done, flag_z, flag_c;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    mul8_fmul_core dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .sgn_sel(sgn_sel),
        .frac(frac), .opa(opa), .opb(opb), .prod_hi(prod_hi),
        .prod_lo(prod_lo), .done(done), .flag_z(flag_z), .flag_c(flag_c)
    );

    // Unshifted 16-bit product from the requirement definitions
    function automatic logic [15:0] ref_raw(logic [1:0] s, logic [7:0] a, logic [7:0] b);
        int ia = (s == 2'd1 || s == 2'd2) ? int'($signed(a)) : int'(a);
        int ib = (s == 2'd1) ? int'($signed(b)) : int'(b);
        int p = ia * ib;
        return p[15:0];
    endfunction

    function automatic logic [15:0] ref_res(logic [1:0] s, logic f, logic [7:0] a, logic [7:0] b);
        logic [15:0] r = ref_raw(s, a, b);
        return f ? {r[14:0], 1'b0} : r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_out(string req, logic [1:0] s, logic f, logic [7:0] a, logic [7:0] b);
        logic [15:0] r = ref_res(s, f, a, b);
        logic [15:0] raw = ref_raw(s, a, b);
        check(req, {prod_hi, prod_lo}, r);
        check({req, " R6 carry"}, flag_c, raw[15]);
        check({req, " R7 zero"}, flag_z, (r == 16'd0));
    endtask

    // One complete multiply; inputs driven at negedge
    task automatic run_one(string req, logic [1:0] s, logic f, logic [7:0] a, logic [7:0] b);
        start = 1'b1; sgn_sel = s; frac = f; opa = a; opb = b;
        @(negedge clk);
        start = 1'b0; opa = ~a; opb = ~b; sgn_sel = ~s;
        check("R8 done low in n+1", done, 1'b0);
        @(negedge clk);
        check("R8 done high in n+2", done, 1'b1);
        check_out(req, s, f, a, b);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 done", done, 1'b0);
        check("R11 product", {prod_hi, prod_lo}, 16'h0000);
        check("R11 flags", {flag_z, flag_c}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners
        run_one("R1 ff*ff", 2'd0, 1'b0, 8'hFF, 8'hFF);
        check("R1 value", {prod_hi, prod_lo}, 16'hFE01);
        run_one("R2 -128*-128", 2'd1, 1'b0, 8'h80, 8'h80);
        check("R2 value", {prod_hi, prod_lo}, 16'h4000);
        run_one("R5 frac -128*-128", 2'd1, 1'b1, 8'h80, 8'h80);
        check("R5 value", {prod_hi, prod_lo}, 16'h8000);
        run_one("R2 -1*-1", 2'd1, 1'b0, 8'hFF, 8'hFF);
        check("R2 value", {prod_hi, prod_lo}, 16'h0001);
        run_one("R3 -1*255", 2'd2, 1'b0, 8'hFF, 8'hFF);
        check("R3 value", {prod_hi, prod_lo}, 16'hFF01);
        check("R6 carry su", flag_c, 1'b1);
        run_one("R3 frac -1*255", 2'd2, 1'b1, 8'hFF, 8'hFF);
        check("R5 shift drops bit15", {prod_hi, prod_lo}, 16'hFE02);
        run_one("R4 code3 ff*ff", 2'd3, 1'b0, 8'hFF, 8'hFF);
        check("R4 value", {prod_hi, prod_lo}, 16'hFE01);
        run_one("R7 zero", 2'd1, 1'b1, 8'h00, 8'h93);
        check("R7 flag", flag_z, 1'b1);
        run_one("R1 frac ff*ff", 2'd0, 1'b1, 8'hFF, 8'hFF);
        check("R6 carry pre-shift", flag_c, 1'b1);

        // R9: no start, outputs and done hold
        repeat (5) begin
            @(negedge clk);
            check("R9 done idle", done, 1'b0);
            check("R9 hold", {prod_hi, prod_lo}, 16'hFC02);
        end

        // R10: back-to-back starts
        start = 1'b1; sgn_sel = 2'd0; frac = 1'b0; opa = 8'd3; opb = 8'd5;
        @(negedge clk);
        sgn_sel = 2'd1; opa = 8'hFE; opb = 8'd7;
        @(negedge clk);
        check("R10 first done", done, 1'b1);
        check("R10 first", {prod_hi, prod_lo}, 16'd15);
        sgn_sel = 2'd2; frac = 1'b1; opa = 8'h81; opb = 8'hC0;
        @(negedge clk);
        start = 1'b0;
        check("R10 second done", done, 1'b1);
        check("R10 second", {prod_hi, prod_lo}, 16'hFFF2);
        @(negedge clk);
        check("R10 third done", done, 1'b1);
        check("R10 third", {prod_hi, prod_lo}, ref_res(2'd2, 1'b1, 8'h81, 8'hC0));
        @(negedge clk);
        check("R10 done drops", done, 1'b0);

        // Constrained random across all modes
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 300; i++) begin
            logic [1:0] s = 2'($urandom_range(0, 3));
            logic f = 1'($urandom_range(0, 1));
            logic [7:0] a = 8'($urandom);
            logic [7:0] b = 8'($urandom);
            if (i % 17 == 0) a = 8'h80;
            if (i % 23 == 0) b = 8'h00;
            case (s)
                2'd0: run_one("R1 random", s, f, a, b);
                2'd1: run_one("R2 random", s, f, a, b);
                2'd2: run_one("R3 random", s, f, a, b);
                default: run_one("R4 random", s, f, a, b);
            endcase
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule